// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block walks an SD or MMC card from power-up to a usable state over the SPI-mode command set. It never shifts bits itself. It drives a separate command engine through a small request/acknowledge interface. For each operation it presents one of two things:

- a dummy-byte request, which clocks one 0xFF byte with chip select held high;
- a full command: index, 32-bit argument, CRC byte, and a flag asking for four extra response bytes.

It then waits for the engine's completion pulse. On that pulse it reads the returned status byte and any extra bytes, and picks the next step from them.

The card ends up in one of five classes: failed, MMC, SD version 1, SD version 2 with byte addressing, or SD version 2 with block addressing. After classification the block programs a 512-byte block length. When that succeeds it raises `ready` and switches the SPI clock select from the slow setup rate to the transfer rate. An address multiplier output tells a downstream data engine whether block numbers must be scaled to byte addresses.

A one-cycle `start` pulse begins the sequence, and a new pulse restarts it from the dummy-byte phase at any time.

Top module: `sdinit_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `ready`, `cmd_go` and `spi_fast` are 0, `card_type` is 0 (none/failed) and `addr_mult` is 512.
- R2: A `start` pulse first issues exactly 16 dummy-byte operations (`cmd_dummy`=1), all with `spi_fast`=0, before any command is issued.
- R3: The first command is index 0 with argument 0 and CRC byte 0x95. A status byte other than 0x01 ends in the failed state: `busy`=0, `ready`=0, `card_type`=0.
- R4: The next command is index 8 with argument 0x000001AA, CRC byte 0x87 and `cmd_extra_en`=1. Status 0x01 selects the version-2 path, status 0x05 selects the version-1 path, and any other value fails.
- R5: Every index-41 command is immediately preceded by an index-55 command. On the version-2 path index 41 carries argument 0x40000000; otherwise it carries argument 0. Every command other than index 8 uses CRC byte 0x95.
- R6: On the version-2 path, status 0 from index 41 is followed by index 58 with `cmd_extra_en`=1. If `rsp_extra` bit 30 is set (bit 6 of the first extra byte), `card_type` becomes 4 and `addr_mult` becomes 1. If it is clear, `card_type` becomes 3 and `addr_mult` is 512. A nonzero status from index 58 fails.
- R7: On the version-1 path the first index-41 status decides the class. Status 0 or 1 gives `card_type` 2. For status 1, the index-55/41 pair repeats until status 0. Any larger status gives `card_type` 1 (MMC), and index 1 with argument 0 repeats until status 0.
- R8: A retry loop that receives MAX_TRIES consecutive nonzero statuses from its repeated command ends in the failed state.
- R9: After classification, index 16 with argument 512 is issued. Status 0 raises `ready` and `spi_fast` and keeps `card_type`. A nonzero status fails and clears `card_type` to 0.
- R10: A `start` pulse while ready or failed drops `ready` and `spi_fast` on the next cycle, raises `busy`, and reruns the sequence from R2.
- R11: `cmd_go` is a one-cycle pulse. No new `cmd_go` occurs until `cmd_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that (re)starts bring-up |
| cmd_go | output | 1 | One-cycle request to the command engine |
| cmd_dummy | output | 1 | 1: clock one 0xFF byte with chip select high; 0: send a command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | CRC byte to send with the command |
| cmd_extra_en | output | 1 | Engine must read four bytes after the status byte |
| cmd_done | input | 1 | One-cycle completion pulse from the engine |
| rsp_r1 | input | 8 | Status byte returned with `cmd_done` |
| rsp_extra | input | 32 | Extra bytes, first received in bits 31:24 |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Card initialized |
| spi_fast | output | 1 | 1 selects the transfer clock, 0 the setup clock |
| card_type | output | 3 | 0 none/failed, 1 MMC, 2 SD v1, 3 SD v2 byte, 4 SD v2 block |
| addr_mult | output | 10 | Block-to-address multiplier (1 or 512) |

## Verification
The assertions assume the command engine behaves correctly. It answers each `cmd_go` with exactly one `cmd_done`, never pulses `cmd_done` without a request outstanding, and holds `rsp_r1` valid in the done cycle. They also assume `start` is only pulsed while no request is outstanding. The bench's engine model meets this by construction. It answers every request after a fixed two-cycle latency and pulses done for one cycle. It pulses `start` only after `busy` has fallen, so restarts come from the ready or failed states.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [2:0] {
        CARD_NONE    = 3'd0,
        CARD_MMC     = 3'd1,
        CARD_SD1     = 3'd2,
        CARD_SD2     = 3'd3,
        CARD_SD2_BLK = 3'd4
    } card_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRIME,
        ST_RESET,
        ST_IFCOND,
        ST_V2_APP,
        ST_V2_OPC,
        ST_V2_OCR,
        ST_V1_APP0,
        ST_V1_OPC0,
        ST_V1_APP,
        ST_V1_OPC,
        ST_MMC_OPC,
        ST_BLKLEN,
        ST_READY,
        ST_FAILED
    } step_e;

    typedef struct packed {
        logic        issue;
        logic        dummy;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  crc;
        logic        extra;
    } cmd_s;

    localparam logic [7:0]  CRC_PLAIN   = 8'h95;
    localparam logic [7:0]  CRC_IFCOND  = 8'h87;
    localparam logic [31:0] ARG_IFCOND  = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS     = 32'h4000_0000;
    localparam logic [7:0]  R1_IDLE     = 8'h01;
    localparam logic [7:0]  R1_IDLE_ILL = 8'h05;
    localparam int          OCR_CCS_BIT = 30;

    function automatic cmd_s step_cmd(step_e s, logic [31:0] blk_bytes);
        cmd_s c;
        c = '{issue: 1'b1, dummy: 1'b0, idx: 6'd0, arg: 32'd0,
              crc: CRC_PLAIN, extra: 1'b0};
        unique case (s)
            ST_PRIME:   c.dummy = 1'b1;
            ST_RESET:   c.idx = 6'd0;
            ST_IFCOND:  begin c.idx = 6'd8; c.arg = ARG_IFCOND;
                              c.crc = CRC_IFCOND; c.extra = 1'b1; end
            ST_V2_APP,
            ST_V1_APP0,
            ST_V1_APP:  c.idx = 6'd55;
            ST_V2_OPC:  begin c.idx = 6'd41; c.arg = ARG_HCS; end
            ST_V1_OPC0,
            ST_V1_OPC:  c.idx = 6'd41;
            ST_MMC_OPC: c.idx = 6'd1;
            ST_V2_OCR:  begin c.idx = 6'd58; c.extra = 1'b1; end
            ST_BLKLEN:  begin c.idx = 6'd16; c.arg = blk_bytes; end
            default:    c.issue = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdinit_cmdmap.sv
module sdinit_cmdmap
    import sdinit_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  step_e step,
    output cmd_s  cmd
);
    localparam logic [31:0] BLK_ARG = 32'(BLOCK_BYTES);

    always_comb cmd = step_cmd(step, BLK_ARG);
endmodule

// File: rtl/sdinit_retry.sv
module sdinit_retry #(
    parameter int MAX_TRIES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic bump,
    output logic expired
);
    localparam int CW = $clog2(MAX_TRIES + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (bump && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = bump && (cnt_q == LAST);
endmodule

// File: rtl/sdinit_fsm.sv
module sdinit_fsm
    import sdinit_pkg::*;
#(
    parameter int PRIME_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       issue,
    input  logic       cmd_done,
    input  logic [7:0] rsp_r1,
    input  logic [31:0] rsp_extra,
    input  logic       expired,
    output step_e      step,
    output logic       go,
    output logic       loop_clear,
    output logic       loop_bump,
    output card_e      card
);
    localparam int PW = (PRIME_BYTES > 1) ? $clog2(PRIME_BYTES) : 1;
    localparam logic [PW-1:0] PRIME_LAST = PW'(PRIME_BYTES - 1);

    step_e         state_q, state_d;
    card_e         card_q, card_d;
    logic [PW-1:0] prime_q, prime_d;
    logic          wait_q;
    logic          ack, r1_zero, in_loop, opc_loop;

    assign ack      = cmd_done && wait_q;
    assign go       = issue && !wait_q;
    assign r1_zero  = (rsp_r1 == 8'h00);
    assign opc_loop = (state_q == ST_V2_OPC) || (state_q == ST_V1_OPC) ||
                      (state_q == ST_MMC_OPC);
    assign in_loop  = opc_loop || (state_q == ST_V2_APP) || (state_q == ST_V1_APP);
    assign loop_clear = !in_loop;
    assign loop_bump  = ack && opc_loop && !r1_zero;

    always_comb begin
        state_d = state_q;
        card_d  = card_q;
        prime_d = prime_q;
        if (ack) begin
            unique case (state_q)
                ST_PRIME: begin
                    prime_d = prime_q + 1'b1;
                    if (prime_q == PRIME_LAST) begin
                        state_d = ST_RESET;
                        prime_d = '0;
                    end
                end
                ST_RESET:   state_d = (rsp_r1 == R1_IDLE) ? ST_IFCOND : ST_FAILED;
                ST_IFCOND: begin
                    if (rsp_r1 == R1_IDLE)          state_d = ST_V2_APP;
                    else if (rsp_r1 == R1_IDLE_ILL) state_d = ST_V1_APP0;
                    else                            state_d = ST_FAILED;
                end
                ST_V2_APP:  state_d = ST_V2_OPC;
                ST_V2_OPC: begin
                    if (r1_zero)      state_d = ST_V2_OCR;
                    else if (expired) state_d = ST_FAILED;
                    else              state_d = ST_V2_APP;
                end
                ST_V2_OCR: begin
                    if (!r1_zero) state_d = ST_FAILED;
                    else begin
                        state_d = ST_BLKLEN;
                        card_d  = rsp_extra[OCR_CCS_BIT] ? CARD_SD2_BLK : CARD_SD2;
                    end
                end
                ST_V1_APP0: state_d = ST_V1_OPC0;
                ST_V1_OPC0: begin
                    if (r1_zero) begin
                        card_d = CARD_SD1; state_d = ST_BLKLEN;
                    end else if (rsp_r1 == R1_IDLE) begin
                        card_d = CARD_SD1; state_d = ST_V1_APP;
                    end else begin
                        card_d = CARD_MMC; state_d = ST_MMC_OPC;
                    end
                end
                ST_V1_APP:  state_d = ST_V1_OPC;
                ST_V1_OPC: begin
                    if (r1_zero)      state_d = ST_BLKLEN;
                    else if (expired) state_d = ST_FAILED;
                    else              state_d = ST_V1_APP;
                end
                ST_MMC_OPC: begin
                    if (r1_zero)      state_d = ST_BLKLEN;
                    else if (expired) state_d = ST_FAILED;
                end
                ST_BLKLEN:  state_d = r1_zero ? ST_READY : ST_FAILED;
                default:    state_d = state_q;
            endcase
        end
        if (state_d == ST_FAILED)
            card_d = CARD_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            card_q  <= CARD_NONE;
            prime_q <= '0;
            wait_q  <= 1'b0;
        end else if (start) begin
            state_q <= ST_PRIME;
            card_q  <= CARD_NONE;
            prime_q <= '0;
            wait_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            card_q  <= card_d;
            prime_q <= prime_d;
            if (go)       wait_q <= 1'b1;
            else if (ack) wait_q <= 1'b0;
        end
    end

    assign step = state_q;
    assign card = card_q;
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int MAX_TRIES   = 5000,
    parameter int PRIME_BYTES = 16,
    parameter int BLOCK_BYTES = 512,
    parameter int MULT_W      = $clog2(BLOCK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cmd_go,
    output logic              cmd_dummy,
    output logic [5:0]        cmd_idx,
    output logic [31:0]       cmd_arg,
    output logic [7:0]        cmd_crc,
    output logic              cmd_extra_en,
    input  logic              cmd_done,
    input  logic [7:0]        rsp_r1,
    input  logic [31:0]       rsp_extra,
    output logic              busy,
    output logic              ready,
    output logic              spi_fast,
    output logic [2:0]        card_type,
    output logic [MULT_W-1:0] addr_mult
);
    step_e step;
    cmd_s  cmd;
    card_e card;
    logic  loop_clear, loop_bump, expired;

    sdinit_cmdmap #(.BLOCK_BYTES(BLOCK_BYTES)) map_i (
        .step (step),
        .cmd  (cmd)
    );

    sdinit_retry #(.MAX_TRIES(MAX_TRIES)) retry_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (loop_clear),
        .bump    (loop_bump),
        .expired (expired)
    );

    sdinit_fsm #(.PRIME_BYTES(PRIME_BYTES)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .issue      (cmd.issue),
        .cmd_done   (cmd_done),
        .rsp_r1     (rsp_r1),
        .rsp_extra  (rsp_extra),
        .expired    (expired),
        .step       (step),
        .go         (cmd_go),
        .loop_clear (loop_clear),
        .loop_bump  (loop_bump),
        .card       (card)
    );

    assign cmd_dummy    = cmd.dummy;
    assign cmd_idx      = cmd.idx;
    assign cmd_arg      = cmd.arg;
    assign cmd_crc      = cmd.crc;
    assign cmd_extra_en = cmd.extra;

    assign ready     = (step == ST_READY);
    assign spi_fast  = ready;
    assign busy      = (step != ST_IDLE) && (step != ST_READY) && (step != ST_FAILED);
    assign card_type = card;
    assign addr_mult = (card == CARD_SD2_BLK) ? MULT_W'(1) : MULT_W'(BLOCK_BYTES);
endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk #(
    parameter int MULT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cmd_go,
    input logic              cmd_dummy,
    input logic [5:0]        cmd_idx,
    input logic [31:0]       cmd_arg,
    input logic [7:0]        cmd_crc,
    input logic              cmd_extra_en,
    input logic              cmd_done,
    input logic [7:0]        rsp_r1,
    input logic              busy,
    input logic              ready,
    input logic              spi_fast,
    input logic [2:0]        card_type,
    input logic [MULT_W-1:0] addr_mult
);
    assert_go_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> !cmd_go);

    assert_ready_fast_R9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (spi_fast && card_type != 3'd0));

    assert_ready_after_blklen_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(cmd_done && rsp_r1 == 8'h00 && cmd_idx == 6'd16));

    assert_restart_drops_ready_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ready && busy));

    assert_ifcond_fields_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !cmd_dummy && cmd_idx == 6'd8) |->
            (cmd_arg == 32'h0000_01AA && cmd_crc == 8'h87 && cmd_extra_en));

    assert_prime_slow_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && cmd_dummy) |-> (!spi_fast && busy));

    assert_block_mult_R6: assert property (@(posedge clk) disable iff (rst)
        (ready && addr_mult == MULT_W'(1)) |-> (card_type == 3'd4));
endmodule

bind sdinit_seq sdinit_seq_chk #(.MULT_W(MULT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cmd_go       (cmd_go),
    .cmd_dummy    (cmd_dummy),
    .cmd_idx      (cmd_idx),
    .cmd_arg      (cmd_arg),
    .cmd_crc      (cmd_crc),
    .cmd_extra_en (cmd_extra_en),
    .cmd_done     (cmd_done),
    .rsp_r1       (rsp_r1),
    .busy         (busy),
    .ready        (ready),
    .spi_fast     (spi_fast),
    .card_type    (card_type),
    .addr_mult    (addr_mult)
);

// File: tb/sdinit_seq_tb_top.sv
module sdinit_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TRIES      = 4;
    localparam int LAT        = 2;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmd_go, cmd_dummy, cmd_extra_en;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_crc;
    logic        cmd_done = 1'b0;
    logic [7:0]  rsp_r1 = 8'hFF;
    logic [31:0] rsp_extra = '0;
    logic        busy, ready, spi_fast;
    logic [2:0]  card_type;
    logic [9:0]  addr_mult;

    int checks = 0;
    int errors = 0;
    int dummies = 0;
    int cycles = 0;
    logic [37:0] exp_q[$];
    logic [39:0] rsp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdinit_seq #(.MAX_TRIES(TRIES)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cmd_go(cmd_go), .cmd_dummy(cmd_dummy), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .cmd_crc(cmd_crc), .cmd_extra_en(cmd_extra_en),
        .cmd_done(cmd_done), .rsp_r1(rsp_r1), .rsp_extra(rsp_extra),
        .busy(busy), .ready(ready), .spi_fast(spi_fast),
        .card_type(card_type), .addr_mult(addr_mult)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int idx, input logic [31:0] arg,
                        input logic [7:0] r1, input logic [31:0] extra);
        exp_q.push_back({6'(idx), arg});
        rsp_q.push_back({r1, extra});
    endtask

    // Command engine model and scoreboard monitor
    initial begin
        int pend = 0;
        logic [7:0]  pr1 = 8'hFF;
        logic [31:0] pex = '0;
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            cmd_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cmd_done = 1'b1; rsp_r1 = pr1; rsp_extra = pex;
                end
            end
            if (cmd_go) begin
                chk(pend == 0 && !cmd_done, "R11 overlapping request", pend, 0);
                pend = LAT;
                if (cmd_dummy) begin
                    dummies++;
                    chk(!spi_fast, "R2 dummy at slow clock", spi_fast, 0);
                    pr1 = 8'hFF; pex = '0;
                end else begin
                    logic [37:0] e;
                    logic [39:0] r;
                    if (exp_q.size() == 0) begin
                        chk(0, "R5 unexpected command", cmd_idx, 0);
                        pr1 = 8'hFF; pex = '0;
                    end else begin
                        e = exp_q.pop_front();
                        r = rsp_q.pop_front();
                        chk({cmd_idx, cmd_arg} == e, "R5 command index/argument",
                            {cmd_idx, cmd_arg}, e);
                        chk(cmd_crc == ((e[37:32] == 6'd8) ? 8'h87 : 8'h95),
                            "R4 crc byte", cmd_crc, (e[37:32] == 6'd8) ? 8'h87 : 8'h95);
                        chk(cmd_extra_en == (e[37:32] == 6'd8 || e[37:32] == 6'd58),
                            "R6 extra bytes flag", cmd_extra_en, 0);
                        if (e[37:32] == 6'd0 && e[31:0] == 32'd0)
                            chk(dummies == 16, "R2 dummy count before first command", dummies, 16);
                        pr1 = r[39:32]; pex = r[31:0];
                    end
                end
            end
        end
    end

    task automatic run(input string req, input int exp_type, input bit exp_ready);
        int n = 0;
        @(negedge clk);
        dummies = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!ready && busy && !spi_fast, {req, " R10 start drops ready"}, {ready, busy, spi_fast}, 3'b010);
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(ready == exp_ready, {req, " ready"}, ready, exp_ready);
        chk(spi_fast == exp_ready, {req, " R9 clock select"}, spi_fast, exp_ready);
        chk(card_type == 3'(exp_type), {req, " card type"}, card_type, exp_type);
        chk(addr_mult == ((exp_type == 4) ? 10'd1 : 10'd512), {req, " R6 addr_mult"},
            addr_mult, (exp_type == 4) ? 1 : 512);
        chk(exp_q.size() == 0, {req, " all expected commands issued"}, exp_q.size(), 0);
        exp_q.delete();
        rsp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !ready && !cmd_go && !spi_fast, "R1 reset outputs",
            {busy, ready, cmd_go, spi_fast}, 0);
        chk(card_type == 3'd0 && addr_mult == 10'd512, "R1 reset type", card_type, 0);

        // R3: reset command answered with a wrong status
        step(0, 0, 8'h00, 0);
        run("R3", 0, 0);

        // R4: interface-condition command rejected oddly
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h09, 0);
        run("R4", 0, 0);

        // R6: version 2, block addressed, one ACMD41 retry
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h01, 32'h0000_01AA);
        step(55, 0, 8'h01, 0);
        step(41, 32'h4000_0000, 8'h01, 0);
        step(55, 0, 8'h01, 0);
        step(41, 32'h4000_0000, 8'h00, 0);
        step(58, 0, 8'h00, 32'hC0FF_8000);
        step(16, 512, 8'h00, 0);
        run("R6 v2 block", 4, 1);

        // R10 + R6: restart from ready, version 2 byte addressed
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h01, 32'h0000_01AA);
        step(55, 0, 8'h00, 0);
        step(41, 32'h4000_0000, 8'h00, 0);
        step(58, 0, 8'h00, 32'h80FF_8000);
        step(16, 512, 8'h00, 0);
        run("R10 R6 v2 byte", 3, 1);

        // R7: version 1 SD with two idle answers
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h05, 0);
        step(55, 0, 8'h01, 0);
        step(41, 0, 8'h01, 0);
        step(55, 0, 8'h01, 0);
        step(41, 0, 8'h01, 0);
        step(55, 0, 8'h01, 0);
        step(41, 0, 8'h00, 0);
        step(16, 512, 8'h00, 0);
        run("R7 sd1", 2, 1);

        // R7: MMC via CMD1 loop
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h05, 0);
        step(55, 0, 8'h05, 0);
        step(41, 0, 8'h05, 0);
        step(1, 0, 8'h01, 0);
        step(1, 0, 8'h00, 0);
        step(16, 512, 8'h00, 0);
        run("R7 mmc", 1, 1);

        // R8: version 2 ACMD41 never leaves idle
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h01, 0);
        for (int i = 0; i < TRIES; i++) begin
            step(55, 0, 8'h01, 0);
            step(41, 32'h4000_0000, 8'h01, 0);
        end
        run("R8 timeout", 0, 0);

        // R9: block length rejected after direct v1 success
        step(0, 0, 8'h01, 0);
        step(8, 32'h1AA, 8'h05, 0);
        step(55, 0, 8'h01, 0);
        step(41, 0, 8'h00, 0);
        step(16, 512, 8'h04, 0);
        run("R9 blklen fail", 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule